// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Register

This block gathers the event outputs of two DMA channels, one moving data from memory toward a serial output and one moving data from a serial input into memory, together with two bus-abort indications. It holds them in one 8-bit status register that the host reads. A separate mask register decides which status bits may drive the single interrupt request line.

A mode bit in the control register sets how the channel event bits behave. In level mode each event bit mirrors its live condition, one clock after the condition. In edge mode a rising condition sets the bit, and the bit stays set until the host writes a 1 to it. Writing a 0 never clears a bit. The two abort bits use their own rule in both modes: they are set while an abort is reported, and a read of the status register clears them. The host reaches all three registers through a plain port with address, write data, write strobe, read strobe and read data. Read data is combinational from the current register contents.

Top module: `dma_irq_stat`

## Requirements
- R1: After reset the control, mask and status registers are all zero, which selects level mode, and `irq` is low.
- R2: The control register sits at index 0x0. Bit 6 selects the mode (0 = level, 1 = edge). All other control bits read as 0.
- R3: In level mode, status bits 0 to 3 equal the `evt_i` value sampled at the previous clock edge. Writes to the status register do not change them.
- R4: In edge mode, a 0-to-1 change of `evt_i[n]` sets status bit n. The bit stays set until a write to the status register at index 0x6 with bit n of the write data at 1.
- R5: A write to the status register with a 0 in any bit position leaves that status bit unchanged.
- R6: In edge mode, if a rising event and a write-1 clear of the same bit fall in the same cycle, the bit ends up set.
- R7: Status bits map to inputs as follows: bit 0 = `evt_i[0]` (write channel reached its interrupt address), bit 1 = `evt_i[1]` (write channel reached its end address), bit 2 = `evt_i[2]` (read channel reached its interrupt address), bit 3 = `evt_i[3]` (read channel reached its end address).
- R8: Status bits 4 and 5 follow `abort_i[0]` and `abort_i[1]`. Each is set in any cycle its abort input is high. Each is cleared by a read (`reg_rd`) of index 0x6 unless its abort input is high in that same read cycle. Writes have no effect on them, in either mode.
- R9: The mask register sits at index 0x5 and reads back all 8 bits as written. `irq` is high exactly when some status bit and the matching mask bit are both 1.
- R10: Status bits 6 and 7 always read as 0. Any index other than 0x0, 0x5 or 0x6 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 6 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe; the write takes effect at the clock edge |
| reg_rd | input | 1 | Read strobe; a read of index 0x6 clears the abort bits |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_i | input | 4 | DMA channel event conditions, mapped as in R7 |
| abort_i | input | 2 | Bus abort conditions |
| irq | output | 1 | Interrupt request |

## Verification
Held conditions and single-cycle pulses are applied in both modes. A pulse that is later cleared separates edge latching from level following, and a condition that stays high across a clear shows that a held level does not set the bit again. Writes are tried with all-zero, partial and matching data, and one write clear is placed in the same cycle as the event it clears. Abort pulses are placed both before and during a status read, so read-clear can be told apart from set priority. Long random runs then mix mode changes, mask changes and reads of unmapped indices against a bench model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Next value of one channel event bit.
  function automatic logic evt_bit_next(input logic cur, input logic live,
                                        input logic prev, input logic clr,
                                        input logic edge_mode);
    logic rise;
    rise = live & ~prev;
    if (edge_mode) return (cur & ~clr) | rise;
    else           return live;
  endfunction

  // Next value of one abort flag: a hit wins over the read clear.
  function automatic logic abort_bit_next(input logic cur, input logic hit,
                                          input logic rd_clr);
    return (cur & ~rd_clr) | hit;
  endfunction

endpackage

// File: rtl/irq_stat_bit.sv
module irq_stat_bit
  import dma_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode_i,
  input  logic live_i,
  input  logic clr_i,
  output logic bit_o
);
  logic prev_q;
  logic bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      prev_q <= live_i;
      bit_q  <= evt_bit_next(bit_q, live_i, prev_q, clr_i, edge_mode_i);
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/irq_abort_flag.sv
module irq_abort_flag
  import dma_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic rd_clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= abort_bit_next(flag_q, hit_i, rd_clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int CTRL_IDX = 0,
  parameter int MASK_IDX = 5,
  parameter int MODE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              edge_mode_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_IDX);

  logic              mode_q;
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      mask_q <= '0;
    end else if (wr_i) begin
      if (addr_i == CTRL_A) mode_q <= wdata_i[MODE_BIT];
      if (addr_i == MASK_A) mask_q <= wdata_i;
    end
  end

  assign edge_mode_o = mode_q;
  assign mask_o      = mask_q;
endmodule

// File: rtl/dma_irq_stat.sv
module dma_irq_stat #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int NUM_EVT  = 4,
  parameter int NUM_ABT  = 2,
  parameter int CTRL_IDX = 0,
  parameter int MASK_IDX = 5,
  parameter int STAT_IDX = 6,
  parameter int MODE_BIT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_wr,
  input  logic               reg_rd,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_ABT-1:0] abort_i,
  output logic               irq
);
  localparam int NUM_SRC = NUM_EVT + NUM_ABT;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_IDX);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);

  logic               edge_mode;
  logic [DATA_W-1:0]  mask_q;
  logic [NUM_EVT-1:0] ev_bits;
  logic [NUM_ABT-1:0] ab_bits;
  logic [NUM_SRC-1:0] stat_all;
  logic               stat_wr;
  logic               stat_rd;

  assign stat_wr = reg_wr && (reg_addr == STAT_A);
  assign stat_rd = reg_rd && (reg_addr == STAT_A);

  irq_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_IDX(CTRL_IDX),
    .MASK_IDX(MASK_IDX), .MODE_BIT(MODE_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .edge_mode_o(edge_mode), .mask_o(mask_q)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    irq_stat_bit u_bit (
      .clk(clk), .rst_n(rst_n), .edge_mode_i(edge_mode),
      .live_i(evt_i[g]), .clr_i(stat_wr & reg_wdata[g]),
      .bit_o(ev_bits[g])
    );
  end

  for (genvar g = 0; g < NUM_ABT; g++) begin : g_abt
    irq_abort_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hit_i(abort_i[g]),
      .rd_clr_i(stat_rd), .flag_o(ab_bits[g])
    );
  end

  assign stat_all = {ab_bits, ev_bits};
  assign irq      = |(stat_all & mask_q[NUM_SRC-1:0]);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      CTRL_A:  reg_rdata[MODE_BIT]      = edge_mode;
      MASK_A:  reg_rdata                = mask_q;
      STAT_A:  reg_rdata[NUM_SRC-1:0]   = stat_all;
      default: reg_rdata                = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_stat_chk.sv
module dma_irq_stat_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int NUM_EVT  = 4,
  parameter int NUM_ABT  = 2,
  parameter int CTRL_IDX = 0,
  parameter int STAT_IDX = 6,
  parameter int MODE_BIT = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic [NUM_EVT-1:0]         evt_i,
  input logic [NUM_ABT-1:0]         abort_i,
  input logic                       irq,
  input logic                       edge_mode,
  input logic [NUM_EVT-1:0]         ev_bits,
  input logic [NUM_ABT-1:0]         ab_bits,
  input logic [NUM_EVT+NUM_ABT-1:0] mask_lo,
  input logic                       stat_wr,
  input logic                       stat_rd
);
  localparam int NUM_SRC = NUM_EVT + NUM_ABT;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);
  localparam logic [DATA_W-1:0] MODE_M = DATA_W'(1) << MODE_BIT;

  logic               seen;
  logic [NUM_EVT-1:0] evt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      evt_d <= '0;
    end else begin
      seen  <= 1'b1;
      evt_d <= evt_i;
    end
  end

  p_ctrl_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_A) |-> ((reg_rdata & ~MODE_M) == '0));

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !edge_mode) |=> (ev_bits == $past(evt_i)));

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && edge_mode && !stat_wr) |=> (((~ev_bits) & $past(ev_bits)) == '0));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && edge_mode) |=> (((~ev_bits) & $past(evt_i & ~evt_d)) == '0));

  p_abort_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> (((~ab_bits) & $past(abort_i)) == '0));

  p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && stat_rd) |=> (ab_bits == $past(abort_i)));

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lo == '0) |-> !irq);

  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (({ab_bits, ev_bits} & mask_lo) != '0) |-> irq);

  p_stat_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STAT_A) |-> (reg_rdata[DATA_W-1:NUM_SRC] == '0));
endmodule

bind dma_irq_stat dma_irq_stat_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .NUM_ABT(NUM_ABT),
  .CTRL_IDX(CTRL_IDX), .STAT_IDX(STAT_IDX), .MODE_BIT(MODE_BIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .evt_i(evt_i), .abort_i(abort_i), .irq(irq), .edge_mode(edge_mode),
  .ev_bits(ev_bits), .ab_bits(ab_bits), .mask_lo(mask_q[NUM_EVT+NUM_ABT-1:0]),
  .stat_wr(stat_wr), .stat_rd(stat_rd)
);

// File: tb/test_dma_irq_stat.sv
`timescale 1ns/1ps
module test_dma_irq_stat;
  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_MASK = 6'h05;
  localparam logic [5:0] A_STAT = 6'h06;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_rdata;
  logic [3:0] evt_i;
  logic [1:0] abort_i;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dma_irq_stat i_dma_irq_stat (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_i(evt_i), .abort_i(abort_i), .irq(irq)
  );

  // Bench model of the register state
  logic       m_edge;
  logic [7:0] m_mask;
  logic [3:0] m_ev, m_prev;
  logic [1:0] m_ab;

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    if (a == A_CTRL) return m_edge ? 8'h40 : 8'h00;
    if (a == A_MASK) return m_mask;
    if (a == A_STAT) return {2'b00, m_ab, m_ev};
    return 8'h00;
  endfunction

  function automatic logic exp_irq();
    return (({m_ab, m_ev} & m_mask[5:0]) != 6'd0);
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [5:0] a, input logic [7:0] wd, input logic wr,
                     input logic rd, input logic [3:0] ev, input logic [1:0] ab,
                     input string tag);
    logic [3:0] rise;
    reg_addr = a; reg_wdata = wd; reg_wr = wr; reg_rd = rd;
    evt_i = ev; abort_i = ab;
    #1;
    check({7'd0, irq}, {7'd0, exp_irq()}, {tag, " irq R9"});
    if (rd) check(reg_rdata, exp_rd(a), tag);
    @(posedge clk);
    rise = ev & ~m_prev;
    if (m_edge) m_ev = (m_ev & ~((wr && a == A_STAT) ? wd[3:0] : 4'd0)) | rise;
    else        m_ev = ev;
    m_ab   = (m_ab & ~{2{rd && a == A_STAT}}) | ab;
    m_prev = ev;
    if (wr && a == A_CTRL) m_edge = wd[6];
    if (wr && a == A_MASK) m_mask = wd;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(A_CTRL, 8'h00, 1'b0, 1'b0, 4'd0, 2'd0, "idle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] ra;
    logic [3:0] hold;
    void'($urandom(32'd4711));
    rst_n = 0; reg_addr = 0; reg_wdata = 0; reg_wr = 0; reg_rd = 0;
    evt_i = 0; abort_i = 0;
    m_edge = 0; m_mask = 0; m_ev = 0; m_prev = 0; m_ab = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({7'd0, irq}, 8'd0, "R1 irq after reset");
    rst_n = 1;
    // R1: reset values
    cyc(A_CTRL, 8'h00, 0, 1, 4'd0, 2'd0, "R1 ctrl");
    cyc(A_MASK, 8'h00, 0, 1, 4'd0, 2'd0, "R1 mask");
    cyc(A_STAT, 8'h00, 0, 1, 4'd0, 2'd0, "R1 stat");
    // R2: mode bit only
    cyc(A_CTRL, 8'hBF, 1, 0, 4'd0, 2'd0, "R2 wr");
    cyc(A_CTRL, 8'h00, 0, 1, 4'd0, 2'd0, "R2 ctrl pad");
    // R9: mask readback
    cyc(A_MASK, 8'hFF, 1, 0, 4'd0, 2'd0, "R9 wr");
    cyc(A_MASK, 8'h00, 0, 1, 4'd0, 2'd0, "R9 mask");
    // R7/R3: level following, bit mapping
    for (int b = 0; b < 4; b++) begin
      cyc(A_STAT, 8'h00, 0, 0, 4'(1 << b), 2'd0, "R7 set");
      cyc(A_STAT, 8'h00, 0, 1, 4'd0, 2'd0, "R7 map");
      cyc(A_STAT, 8'h00, 0, 1, 4'd0, 2'd0, "R3 drop");
    end
    cyc(A_STAT, 8'h00, 0, 0, 4'hA, 2'd0, "R3 hold");
    cyc(A_STAT, 8'hFF, 1, 0, 4'hA, 2'd0, "R3 wr");
    cyc(A_STAT, 8'h00, 0, 1, 4'hA, 2'd0, "R3 wr ignored");
    idle(2);
    // R4: edge mode latching
    cyc(A_CTRL, 8'h40, 1, 0, 4'd0, 2'd0, "R2 edge on");
    cyc(A_CTRL, 8'h00, 0, 1, 4'd0, 2'd0, "R2 ctrl edge");
    cyc(A_STAT, 8'h00, 0, 0, 4'h4, 2'd0, "R4 pulse");
    idle(3);
    cyc(A_STAT, 8'h00, 0, 1, 4'd0, 2'd0, "R4 latched");
    // R5: zeros do not clear
    cyc(A_STAT, 8'h00, 1, 0, 4'd0, 2'd0, "R5 wr0");
    cyc(A_STAT, 8'hFB, 1, 0, 4'd0, 2'd0, "R5 wrFB");
    cyc(A_STAT, 8'h00, 0, 1, 4'd0, 2'd0, "R5 still set");
    cyc(A_STAT, 8'h04, 1, 0, 4'd0, 2'd0, "R4 clr");
    cyc(A_STAT, 8'h00, 0, 1, 4'd0, 2'd0, "R4 cleared");
    // R4: held condition does not re-set after clear
    cyc(A_STAT, 8'h00, 0, 0, 4'h1, 2'd0, "R4 hold rise");
    cyc(A_STAT, 8'h01, 1, 0, 4'h1, 2'd0, "R4 hold clr");
    cyc(A_STAT, 8'h00, 0, 1, 4'h1, 2'd0, "R4 no reset");
    // R6: set wins over clear
    cyc(A_STAT, 8'h00, 0, 0, 4'h0, 2'd0, "R6 prep");
    cyc(A_STAT, 8'h02, 1, 0, 4'h2, 2'd0, "R6 both");
    cyc(A_STAT, 8'h00, 0, 1, 4'h0, 2'd0, "R6 set wins");
    // R8: abort read-to-clear
    cyc(A_STAT, 8'h00, 0, 0, 4'h0, 2'b10, "R8 pulse");
    cyc(A_STAT, 8'h30, 1, 0, 4'h0, 2'b00, "R8 wr ignored");
    cyc(A_STAT, 8'h00, 0, 1, 4'h0, 2'b00, "R8 read set");
    cyc(A_STAT, 8'h00, 0, 1, 4'h0, 2'b01, "R8 read cleared");
    cyc(A_STAT, 8'h00, 0, 1, 4'h0, 2'b00, "R8 hit during read");
    cyc(A_STAT, 8'h00, 0, 1, 4'h0, 2'b00, "R8 final clear");
    // R9: mask gating
    cyc(A_STAT, 8'h00, 0, 0, 4'h8, 2'd0, "R9 ev");
    cyc(A_MASK, 8'h00, 1, 0, 4'h0, 2'd0, "R9 mask off");
    cyc(A_MASK, 8'h08, 1, 0, 4'h0, 2'd0, "R9 mask on");
    cyc(A_MASK, 8'h00, 0, 1, 4'h0, 2'd0, "R9 irq on");
    // R10: unmapped index and padding
    cyc(6'h03, 8'h00, 0, 1, 4'h0, 2'd0, "R10 unmapped");
    cyc(6'h3F, 8'h00, 0, 1, 4'h0, 2'd0, "R10 unmapped hi");
    // Random mix
    hold = 4'd0;
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic wr, rd;
      r = $urandom % 8;
      if (r < 2) ra = A_CTRL;
      else if (r < 5) ra = A_STAT;
      else if (r < 6) ra = A_MASK;
      else ra = 6'($urandom);
      wr = ($urandom % 4) == 0;
      rd = !wr && ($urandom % 2);
      if ($urandom % 3 == 0) hold = 4'($urandom);
      cyc(ra, 8'($urandom), wr, rd, hold,
          ($urandom % 6 == 0) ? 2'($urandom) : 2'd0,
          (ra == A_STAT) ? (m_edge ? "R4 rnd" : "R3 rnd")
          : (ra == A_CTRL) ? "R2 rnd" : (ra == A_MASK) ? "R9 rnd" : "R10 rnd");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule